// File: doc/BRIEF.md
# Wiper Register and Non-Volatile Store Controller

This block is the register file that sits behind the serial port of a digitally controlled potentiometer. It keeps the live wiper code in a volatile register and a small non-volatile array. Entry 0 of that array is the start-up wiper value. Entries 1 to 14 are general-purpose bytes. A control byte at address 10h holds two control bits (volatile select and shutdown, active low) and a read-only busy bit. The serial front end turns bus transactions into single-cycle register accesses on the access port. It pulses `txn_end` when the STOP condition closes a transaction.

Address 0 is shared. With the volatile select bit clear, address 0 targets the start-up value, and a write there also moves the wiper at once. With the bit set, address 0 targets only the wiper register. A non-volatile byte is first held pending. Its commit starts at the following STOP and runs for `WR_CYCLES` clocks, and the busy bit is high for that whole time. While the busy bit is high, writes to the wiper register and the control byte are refused. While `pwr_good` is low the wiper is parked at mid-scale (80h for 8 bits). When power becomes good, the wiper is loaded from the start-up value. Shutdown forces the wiper output to code 0 (the low end) and raises `shdn_en`, and the wiper register itself keeps its value.

The controller is one state machine:
- `ST_PWR_WAIT` goes to `ST_RECALL` when `pwr_good` is sampled high.
- `ST_RECALL` goes to `ST_IDLE` after one cycle.
- `ST_IDLE` goes to `ST_NV_ARMED` on an accepted non-volatile write.
- `ST_NV_ARMED` goes to `ST_NV_BUSY` on `txn_end`.
- `ST_NV_BUSY` goes to `ST_IDLE` when the cycle timer expires, and the byte is committed on that edge.
- From any state, a low `pwr_good` leads to `ST_PWR_WAIT`.

Top module: `potreg_ctrl`

## Requirements
- R1: While `pwr_good` is low (state `ST_PWR_WAIT`), `wiper_code` is 80h and `shdn_en` is 0. Register reads return 00h, and register writes are discarded.
- R2: On the second clock edge after `pwr_good` is first sampled high, `wiper_code` equals the stored start-up value (array entry 0).
- R3: With the control byte's bit 7 (volatile select) set to 1, a write to address 0 changes only the wiper register, and the output follows on the next edge. A read of address 0 returns the wiper register. The stored start-up value is not changed.
- R4: With bit 7 at 0, a write to address 0 loads the wiper register on the next edge. The stored start-up value changes only when the commit ends, and reads of address 0 return the stored value.
- R5: A read of address 10h returns {select bit 7, shutdown bit 6, busy bit 5, 5'b00000}. After power-up recall it reads 40h.
- R6: The busy bit (bit 5) rises on the edge that samples `txn_end` in `ST_NV_ARMED`. It stays 1 for exactly `WR_CYCLES` clocks.
- R7: While the busy bit is 1, writes to the control byte and to the wiper register are ignored. Writes to bit 5 never have any effect.
- R8: Only the first non-volatile write after `ST_IDLE` is committed. Later non-volatile writes, made before the commit ends, are ignored.
- R9: With bit 6 at 0, `wiper_code` is 00h and `shdn_en` is 1. When bit 6 goes back to 1, the output returns to the unchanged wiper register value.
- R10: Address 0Fh and any address above 10h read 00h, and writes to them change nothing.
- R11: General-purpose entries 01h to 0Eh read back the committed byte after the commit ends.
- R12: If `pwr_good` falls during a commit, the pending byte is dropped. After the next recall the control byte reads 40h again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low; also sets the array's reset contents |
| pwr_good | input | 1 | Supply is high enough for reliable array reads |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 8 | Write data |
| txn_end | input | 1 | Pulse at the STOP that closes a write transaction |
| acc_rdata | output | 8 | Read data, registered, valid the cycle after a read strobe |
| wiper_code | output | 8 | Tap code, 00h nearest low terminal, FFh nearest high |
| shdn_en | output | 1 | 1 when the resistor path is opened and wiper tied low |

## Verification
The three kinds of result have different timing, and the bench samples each one in its own cycle:
- **Wiper and shutdown:** `wiper_code` and `shdn_en` change on the edge that samples the write, so the bench reads them at the falling edge just after that edge.
- **Read data:** `acc_rdata` is registered and comes one edge after the read strobe. The recalled wiper value appears two edges after `pwr_good` is sampled high.
- **Busy bit:** the bench checks it with back-to-back control-byte reads that start in the cycle after `txn_end`. It counts how many of them show bit 5 set and compares the count with `WR_CYCLES`.

All stimulus changes on falling edges.

// File: rtl/potreg_pkg.sv
package potreg_pkg;

    typedef enum logic [2:0] {
        ST_PWR_WAIT = 3'd0,
        ST_RECALL   = 3'd1,
        ST_IDLE     = 3'd2,
        ST_NV_ARMED = 3'd3,
        ST_NV_BUSY  = 3'd4
    } pot_state_t;

    // address decode points, behaviour depends on these values
    localparam int unsigned ADR_START  = 0;
    localparam int unsigned ADR_GP_LO  = 1;
    localparam int unsigned ADR_GP_HI  = 14;
    localparam int unsigned ADR_RSVD   = 15;
    localparam int unsigned ADR_CTRL   = 16;
    localparam int unsigned NV_DEPTH   = ADR_GP_HI + 1;

    // control byte bit positions
    localparam int unsigned BIT_VSEL = 7;
    localparam int unsigned BIT_SHDN = 6;
    localparam int unsigned BIT_BUSY = 5;

endpackage

// File: rtl/potreg_nvarray.sv
module potreg_nvarray #(
    parameter int unsigned   DW      = 8,
    parameter int unsigned   DEPTH   = 15,
    parameter int unsigned   AW      = 4,
    parameter logic [DW-1:0] IVR_RST = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [AW-1:0] commit_addr,
    input  logic [DW-1:0] commit_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ivr_data
);

    localparam int unsigned FLAT_W = DW * DEPTH;

    logic [FLAT_W-1:0] cells;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= (g == 0) ? IVR_RST : '0;
                end else if (commit && (commit_addr == AW'(g))) begin
                    q <= commit_data;
                end
            end
            assign cells[g*DW +: DW] = q;
        end
    endgenerate

    always_comb begin
        if (int'(rd_addr) < DEPTH) begin
            rd_data = cells[int'(rd_addr)*DW +: DW];
        end else begin
            rd_data = '0;
        end
    end

    assign ivr_data = cells[DW-1:0];

endmodule

// File: rtl/potreg_wtimer.sv
module potreg_wtimer #(
    parameter int unsigned CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/potreg_rdmux.sv
module potreg_rdmux
    import potreg_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] addr,
    input  logic          vsel,
    input  logic          shdn_n,
    input  logic          busy,
    input  logic [DW-1:0] wiper_reg,
    input  logic [DW-1:0] nv_data,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] ctrl_byte;

    always_comb begin
        ctrl_byte           = '0;
        ctrl_byte[BIT_VSEL] = vsel;
        ctrl_byte[BIT_SHDN] = shdn_n;
        ctrl_byte[BIT_BUSY] = busy;
    end

    always_comb begin
        if (addr == AW'(ADR_START)) begin
            rdata = vsel ? wiper_reg : nv_data;
        end else if ((addr >= AW'(ADR_GP_LO)) && (addr <= AW'(ADR_GP_HI))) begin
            rdata = nv_data;
        end else if (addr == AW'(ADR_CTRL)) begin
            rdata = ctrl_byte;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/potreg_ctrl.sv
module potreg_ctrl
    import potreg_pkg::*;
#(
    parameter int unsigned   DW        = 8,
    parameter int unsigned   ADDR_W    = 5,
    parameter int unsigned   WR_CYCLES = 2000000,
    parameter logic [DW-1:0] IVR_RST   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DW-1:0]     acc_wdata,
    input  logic              txn_end,
    output logic [DW-1:0]     acc_rdata,
    output logic [DW-1:0]     wiper_code,
    output logic              shdn_en
);

    localparam int unsigned   NV_AW   = $clog2(NV_DEPTH);
    localparam logic [DW-1:0] MID_VAL = DW'(1) << (DW - 1);

    pot_state_t state, state_nx;

    logic [DW-1:0]    wr_q;
    logic             vsel_q;
    logic             shdn_n_q;
    logic [NV_AW-1:0] pend_addr;
    logic [DW-1:0]    pend_data;

    logic             op_ok, busy, expired;
    logic             wr_req, hit_start, hit_gp, hit_ctrl;
    logic             nv_req, arm, vol_wr, ctrl_wr;
    logic             tmr_load, tmr_run, commit;
    logic [DW-1:0]    nv_rd, ivr_data, mux_rd;

    // ---------------- decode ----------------
    assign op_ok     = (state == ST_IDLE) || (state == ST_NV_ARMED) || (state == ST_NV_BUSY);
    assign busy      = (state == ST_NV_BUSY);
    assign wr_req    = acc_valid && acc_write && op_ok && pwr_good;
    assign hit_start = (acc_addr == ADDR_W'(ADR_START));
    assign hit_gp    = (acc_addr >= ADDR_W'(ADR_GP_LO)) && (acc_addr <= ADDR_W'(ADR_GP_HI));
    assign hit_ctrl  = (acc_addr == ADDR_W'(ADR_CTRL));
    assign nv_req    = wr_req && ((hit_start && !vsel_q) || hit_gp);
    assign arm       = nv_req && (state == ST_IDLE);
    assign vol_wr    = wr_req && hit_start && vsel_q && !busy;
    assign ctrl_wr   = wr_req && hit_ctrl && !busy;
    assign tmr_load  = (state == ST_NV_ARMED) && txn_end && pwr_good;
    assign tmr_run   = busy;
    assign commit    = busy && expired && pwr_good;

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWR_WAIT: if (pwr_good) state_nx = ST_RECALL;
            ST_RECALL:   state_nx = ST_IDLE;
            ST_IDLE:     if (arm) state_nx = ST_NV_ARMED;
            ST_NV_ARMED: if (txn_end) state_nx = ST_NV_BUSY;
            ST_NV_BUSY:  if (expired) state_nx = ST_IDLE;
            default:     state_nx = ST_PWR_WAIT;
        endcase
        if (!pwr_good) state_nx = ST_PWR_WAIT;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWR_WAIT;
        else        state <= state_nx;
    end

    // ---------------- register datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= MID_VAL;
            vsel_q    <= 1'b0;
            shdn_n_q  <= 1'b1;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (!pwr_good || (state == ST_PWR_WAIT)) begin
            wr_q      <= MID_VAL;
            vsel_q    <= 1'b0;
            shdn_n_q  <= 1'b1;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (state == ST_RECALL) begin
            wr_q <= ivr_data;
        end else begin
            if (vol_wr || (arm && hit_start)) wr_q <= acc_wdata;
            if (ctrl_wr) begin
                vsel_q   <= acc_wdata[BIT_VSEL];
                shdn_n_q <= acc_wdata[BIT_SHDN];
            end
            if (arm) begin
                pend_addr <= acc_addr[NV_AW-1:0];
                pend_data <= acc_wdata;
            end
        end
    end

    // ---------------- read data register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_rdata <= '0;
        end else if (acc_valid && !acc_write) begin
            acc_rdata <= (op_ok && pwr_good) ? mux_rd : '0;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        shdn_en    = !shdn_n_q;
        wiper_code = shdn_n_q ? wr_q : '0;
    end

    // ---------------- sub-blocks ----------------
    potreg_nvarray #(
        .DW      (DW),
        .DEPTH   (NV_DEPTH),
        .AW      (NV_AW),
        .IVR_RST (IVR_RST)
    ) u_nv (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_addr (pend_addr),
        .commit_data (pend_data),
        .rd_addr     (acc_addr[NV_AW-1:0]),
        .rd_data     (nv_rd),
        .ivr_data    (ivr_data)
    );

    potreg_wtimer #(
        .CYCLES (WR_CYCLES)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (expired)
    );

    potreg_rdmux #(
        .DW (DW),
        .AW (ADDR_W)
    ) u_rd (
        .addr      (acc_addr),
        .vsel      (vsel_q),
        .shdn_n    (shdn_n_q),
        .busy      (busy),
        .wiper_reg (wr_q),
        .nv_data   (nv_rd),
        .rdata     (mux_rd)
    );

    // ---------------- assertions ----------------
    // R1
    pwrwait_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWR_WAIT) |-> (wr_q == MID_VAL));

    // R2
    recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RECALL) && pwr_good) |=> (wr_q == $past(ivr_data)));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(txn_end));

    // R7
    busy_ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && acc_valid && acc_write && hit_ctrl && pwr_good)
        |=> ($stable(vsel_q) && $stable(shdn_n_q)));

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_NV_ARMED) || busy)
        |=> (!((state == ST_NV_ARMED) || busy) || ($stable(pend_addr) && $stable(pend_data))));

    // R10
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && (acc_addr == ADDR_W'(ADR_RSVD))) |=> (acc_rdata == '0));

endmodule

// File: tb/sim_potreg_ctrl.sv
`timescale 1ns/1ps
module sim_potreg_ctrl;

    localparam int unsigned CYC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [4:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       txn_end = 1'b0;
    logic [7:0] acc_rdata;
    logic [7:0] wiper_code;
    logic       shdn_en;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    potreg_ctrl #(
        .DW (8), .ADDR_W (5), .WR_CYCLES (CYC), .IVR_RST (8'h33)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .pwr_good (pwr_good),
        .acc_valid (acc_valid), .acc_write (acc_write), .acc_addr (acc_addr),
        .acc_wdata (acc_wdata), .txn_end (txn_end), .acc_rdata (acc_rdata),
        .wiper_code (wiper_code), .shdn_en (shdn_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [7:0] d);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        @(negedge clk);
        d = acc_rdata;
        acc_valid = 1'b0;
    endtask

    task automatic stop_pulse();
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 100; i++) begin
            reg_rd(5'h10, v);
            if (!v[5]) break;
        end
    endtask

    task automatic t_unpowered();
        logic [7:0] v;
        chk("R1 wiper mid-scale", wiper_code, 8'h80);
        chk("R1 shdn_en low", shdn_en, 0);
        reg_wr(5'h10, 8'h80);
        reg_rd(5'h10, v);
        chk("R1 read returns zero", v, 8'h00);
        chk("R1 wiper unchanged", wiper_code, 8'h80);
    endtask

    task automatic t_recall();
        logic [7:0] v;
        pwr_good = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 recalled wiper", wiper_code, 8'h33);
        reg_rd(5'h10, v);
        chk("R5 control default 40h (R1 write ignored)", v, 8'h40);
    endtask

    task automatic t_volatile();
        logic [7:0] v;
        reg_wr(5'h10, 8'hC0);
        reg_rd(5'h10, v);
        chk("R5 control reads C0h", v, 8'hC0);
        reg_wr(5'h00, 8'h5A);
        chk("R3 wiper follows", wiper_code, 8'h5A);
        reg_rd(5'h00, v);
        chk("R3 addr0 reads wiper", v, 8'h5A);
        reg_wr(5'h10, 8'h40);
        reg_rd(5'h00, v);
        chk("R3 start value untouched", v, 8'h33);
    endtask

    task automatic t_nv_start();
        logic [7:0] v;
        int busy_cnt = 0;
        reg_wr(5'h00, 8'h9C);
        chk("R4 wiper updated at once", wiper_code, 8'h9C);
        reg_rd(5'h00, v);
        chk("R4 stored value before commit", v, 8'h33);
        stop_pulse();
        for (int i = 0; i < 3 * CYC; i++) begin
            reg_rd(5'h10, v);
            if (!v[5]) break;
            busy_cnt++;
        end
        chk("R6 busy length", busy_cnt, CYC);
        reg_rd(5'h00, v);
        chk("R4 stored value after commit", v, 8'h9C);
    endtask

    task automatic t_busy_lock();
        logic [7:0] v;
        reg_wr(5'h03, 8'h11);
        stop_pulse();
        reg_wr(5'h10, 8'h00);
        reg_wr(5'h04, 8'hEE);
        reg_rd(5'h10, v);
        chk("R7 control write refused while busy", v, 8'h60);
        wait_idle();
        reg_rd(5'h10, v);
        chk("R7 control after commit", v, 8'h40);
        reg_rd(5'h03, v);
        chk("R11 general byte committed", v, 8'h11);
        reg_rd(5'h04, v);
        chk("R8 write during busy dropped", v, 8'h00);
        reg_wr(5'h10, 8'hE0);
        reg_rd(5'h10, v);
        chk("R7 bit5 not writable", v, 8'hC0);
        reg_wr(5'h10, 8'h40);
    endtask

    task automatic t_one_byte();
        logic [7:0] v;
        reg_wr(5'h05, 8'h22);
        reg_wr(5'h06, 8'h44);
        stop_pulse();
        wait_idle();
        reg_rd(5'h05, v);
        chk("R11 first byte committed", v, 8'h22);
        reg_rd(5'h06, v);
        chk("R8 second byte dropped", v, 8'h00);
    endtask

    task automatic t_shutdown();
        reg_wr(5'h10, 8'hC0);
        reg_wr(5'h00, 8'h70);
        reg_wr(5'h10, 8'h80);
        chk("R9 wiper at low end", wiper_code, 8'h00);
        chk("R9 shdn_en high", shdn_en, 1);
        reg_wr(5'h10, 8'hC0);
        chk("R9 wiper restored", wiper_code, 8'h70);
        chk("R9 shdn_en low again", shdn_en, 0);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        reg_wr(5'h0F, 8'hAA);
        reg_rd(5'h0F, v);
        chk("R10 0Fh reads zero", v, 8'h00);
        reg_wr(5'h12, 8'h55);
        reg_rd(5'h12, v);
        chk("R10 12h reads zero", v, 8'h00);
        reg_rd(5'h10, v);
        chk("R10 control untouched", v, 8'hC0);
        chk("R10 wiper untouched", wiper_code, 8'h70);
    endtask

    task automatic t_power_drop();
        logic [7:0] v;
        reg_wr(5'h10, 8'h40);
        reg_wr(5'h07, 8'h77);
        stop_pulse();
        reg_rd(5'h10, v);
        reg_rd(5'h10, v);
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R12 wiper parked", wiper_code, 8'h80);
        pwr_good = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R12 recall after drop", wiper_code, 8'h9C);
        reg_rd(5'h10, v);
        chk("R12 control default", v, 8'h40);
        reg_rd(5'h07, v);
        chk("R12 aborted byte absent", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_unpowered();
        t_recall();
        t_volatile();
        t_nv_start();
        t_busy_lock();
        t_one_byte();
        t_shutdown();
        t_reserved();
        t_power_drop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule